// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one burst access to a synchronous graphics DRAM. A single-cycle start pulse captures three things: a start column, a burst-length code and an ordering select. From the next cycle on, the block presents one column address per clock. With each address it asserts a valid strobe, and on the final address it raises a last-beat flag.

Two orderings are available for bursts of 2, 4 and 8 beats. The sequential order counts upward and wraps inside the aligned block that the burst length defines. The interleaved order XORs the beat index into the low column bits. A full-page burst walks every column of the page in sequential order, wrapping from the top column back to zero.

A new start pulse always takes priority over a burst that is already running. The old burst stops at once and the new one begins from its own start column.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high reset leaves the block idle, with `col_valid` and `col_last` low in the cycle after reset is sampled, including when reset arrives during a burst.
- R2: The address for beat 0 appears on `col_out` in the cycle after `start` is sampled high, with `col_valid` high, and it equals the captured `start_col`. Each later beat follows exactly one clock after the one before it.
- R3: `len_sel` encodes the burst length as 0 → 1 beat, 1 → 2 beats, 2 → 4 beats, 3 → 8 beats and 7 → full page (256 beats). With `interleave` = 0, the low log2(length) bits of beat n equal (start low bits + n) modulo the length. For example, length 8 from start 5 gives 5,6,7,0,1,2,3,4.
- R4: With `interleave` = 1 and a length of 2, 4 or 8, the low log2(length) bits of beat n equal the start's low bits XOR n. For example, length 8 from start 5 gives 5,4,7,6,1,0,3,2, and length 4 from start 3 gives 3,2,1,0.
- R5: Column bits above the ordered low bits hold the start column's value for the whole burst.
- R6: A full-page burst issues 256 beats, col = (start + n) mod 256, wrapping from 255 to 0. The `interleave` input is ignored for this length.
- R7: `col_last` is high only on the final beat of a burst. In the following cycle `col_valid` is low unless a new start was sampled.
- R8: A length-1 burst issues only the start column, with `col_last` high on that single beat.
- R9: A `start` sampled while a burst is active abandons it. The next cycle shows beat 0 of the new burst, using the new start column, length and ordering.
- R10: The reserved `len_sel` codes 4, 5 and 6 act as a length-1 burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that launches a burst |
| start_col | input | 8 | First column of the burst |
| len_sel | input | 3 | Burst length code |
| interleave | input | 1 | 0 = sequential order, 1 = interleaved order |
| col_out | output | 8 | Current column address |
| col_valid | output | 1 | High while a beat is presented |
| col_last | output | 1 | High on the final beat |

## Verification
The hardest case to reach from the ports is a restart that lands in the middle of a burst, where the old and new bursts differ in both length and ordering. An error here would show up only as a stale beat count or a stale mask. The bench runs part of an 8-beat sequential burst and then pulses `start` during the cycle in which beat 3 is displayed. The new burst is a 4-beat interleaved one at a column with different high bits. The bench expects beat 0 of the new burst in the very next cycle, and it expects no fifth beat from the old burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int COL_W_DEF = 8;

  localparam logic [2:0] LEN_CODE_1    = 3'd0;
  localparam logic [2:0] LEN_CODE_2    = 3'd1;
  localparam logic [2:0] LEN_CODE_4    = 3'd2;
  localparam logic [2:0] LEN_CODE_8    = 3'd3;
  localparam logic [2:0] LEN_CODE_PAGE = 3'd7;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/bcs_cfg_reg.sv
module bcs_cfg_reg
  import bcs_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             interleave,
  output logic [COL_W-1:0] base_col,
  output logic [COL_W-1:0] burst_mask,
  output order_e           order
);
  // Low-bit mask of the burst block; the full page covers every column bit.
  function automatic logic [COL_W-1:0] code_to_mask(input logic [2:0] code);
    case (code)
      LEN_CODE_2:    return COL_W'(1);
      LEN_CODE_4:    return COL_W'(3);
      LEN_CODE_8:    return COL_W'(7);
      LEN_CODE_PAGE: return '1;
      default:       return '0;
    endcase
  endfunction

  logic   page_sel;
  order_e order_d;

  assign page_sel = (len_sel == LEN_CODE_PAGE);
  assign order_d  = (interleave && !page_sel) ? ORD_ILV : ORD_SEQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_col   <= '0;
      burst_mask <= '0;
      order      <= ORD_SEQ;
    end else if (start) begin
      base_col   <= start_col;
      burst_mask <= code_to_mask(len_sel);
      order      <= order_d;
    end
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
  parameter int COL_W = bcs_pkg::COL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] burst_mask,
  output logic [COL_W-1:0] beat,
  output logic             active,
  output logic             final_beat
);
  assign final_beat = active && (beat == burst_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (start) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (active) begin
      if (final_beat) begin
        active <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] burst_mask,
  input  order_e           order,
  input  logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] col
);
  // Only the masked low bits move; the bits above them come from the base.
  function automatic logic [COL_W-1:0] ordered_col(
    input logic [COL_W-1:0] b,
    input logic [COL_W-1:0] m,
    input logic             ilv,
    input logic [COL_W-1:0] n
  );
    logic [COL_W-1:0] low;
    low = ilv ? (b ^ n) : (b + n);
    return (b & ~m) | (low & m);
  endfunction

  assign col = ordered_col(base_col, burst_mask, order == ORD_ILV, beat);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = COL_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             interleave,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last
);
  logic [COL_W-1:0] base_col;
  logic [COL_W-1:0] burst_mask;
  order_e           order;
  logic [COL_W-1:0] beat;
  logic             active;
  logic             final_beat;
  logic             order_ilv;

  assign order_ilv = (order == ORD_ILV);

  bcs_cfg_reg #(.COL_W(COL_W)) u_cfg (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_sel(len_sel), .interleave(interleave),
    .base_col(base_col), .burst_mask(burst_mask), .order(order)
  );

  bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk(clk), .rst(rst), .start(start), .burst_mask(burst_mask),
    .beat(beat), .active(active), .final_beat(final_beat)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_col(base_col), .burst_mask(burst_mask), .order(order),
    .beat(beat), .col(col_out)
  );

  assign col_valid = active;
  assign col_last  = final_beat;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic [COL_W-1:0] burst_mask,
  input logic [COL_W-1:0] beat_idx,
  input logic             order_ilv
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!col_valid && !col_last));

  a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
    start |=> (col_valid && col_out == $past(start_col)));

  a_r3_seq_step: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_last && !start && !order_ilv) |=>
      ((col_out & burst_mask) == (($past(col_out) + 1'b1) & burst_mask)));

  a_r4_ilv_step: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_last && !start && order_ilv) |=>
      ((col_out ^ $past(col_out)) == (beat_idx ^ $past(beat_idx))));

  a_r5_high_fixed: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_last && !start) |=>
      ((col_out & ~burst_mask) == ($past(col_out) & ~burst_mask)));

  a_r7_last_ends: assert property (@(posedge clk) disable iff (rst)
    (col_last && !start) |=> !col_valid);

  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  a_r8_single_beat: assert property (@(posedge clk) disable iff (rst)
    (col_valid && burst_mask == '0) |-> col_last);
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_chk (
  .clk(clk), .rst(rst), .start(start), .start_col(start_col),
  .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
  .burst_mask(burst_mask), .beat_idx(beat), .order_ilv(order_ilv)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_sel = '0;
  logic       interleave = 1'b0;
  logic [7:0] col_out;
  logic       col_valid;
  logic       col_last;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_sel(len_sel), .interleave(interleave),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int beats_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  // Expected column restated from the block-aligned arithmetic.
  function automatic int exp_col(input int s, input int len, input bit ilv, input int n);
    int lo;
    int hi;
    if (len == 256) return (s + n) % 256;
    lo = s % len;
    hi = s - lo;
    if (ilv) return hi + (lo ^ n);
    return hi + ((lo + n) % len);
  endfunction

  task automatic launch(input int s, input int code, input bit ilv);
    start      = 1'b1;
    start_col  = 8'(s);
    len_sel    = 3'(code);
    interleave = ilv;
    @(negedge clk);
    start      = 1'b0;
  endtask

  task automatic check_run(input int s, input int code, input bit ilv,
                           input int count, input string tag);
    int len;
    len = beats_of(code);
    for (int n = 0; n < count; n++) begin
      check(col_valid === 1'b1, {tag, " valid"}, int'(col_valid), 1);
      check(col_out === 8'(exp_col(s, len, ilv, n)), {tag, " col"},
            int'(col_out), exp_col(s, len, ilv, n));
      check(col_last === (n == len - 1), {tag, " last R7"}, int'(col_last),
            int'(n == len - 1));
      @(negedge clk);
    end
    if (count == len)
      check(col_valid === 1'b0, {tag, " end R7"}, int'(col_valid), 0);
  endtask

  task automatic t_reset();
    check(col_valid === 1'b0, "R1 reset valid", int'(col_valid), 0);
    check(col_last === 1'b0, "R1 reset last", int'(col_last), 0);
  endtask

  task automatic t_sequential();
    launch(5, 3, 1'b0); check_run(5, 3, 1'b0, 8, "R3 seq8 s5");
    launch(2, 2, 1'b0); check_run(2, 2, 1'b0, 4, "R3 seq4 s2");
    launch(3, 2, 1'b0); check_run(3, 2, 1'b0, 4, "R3 seq4 s3");
    launch(8'hB7, 1, 1'b0); check_run(8'hB7, 1, 1'b0, 2, "R5 seq2 high");
    launch(8'hCE, 3, 1'b0); check_run(8'hCE, 3, 1'b0, 8, "R5 seq8 high");
  endtask

  task automatic t_interleaved();
    launch(5, 3, 1'b1); check_run(5, 3, 1'b1, 8, "R4 ilv8 s5");
    launch(3, 2, 1'b1); check_run(3, 2, 1'b1, 4, "R4 ilv4 s3");
    launch(2, 2, 1'b1); check_run(2, 2, 1'b1, 4, "R4 ilv4 s2");
    launch(8'h61, 1, 1'b1); check_run(8'h61, 1, 1'b1, 2, "R4 ilv2");
    launch(8'h9A, 3, 1'b1); check_run(8'h9A, 3, 1'b1, 8, "R5 ilv8 high");
  endtask

  task automatic t_full_page();
    launch(8'hFD, 7, 1'b0); check_run(8'hFD, 7, 1'b0, 256, "R6 page seq");
    launch(8'h13, 7, 1'b1); check_run(8'h13, 7, 1'b0, 256, "R6 page ilv ignored");
  endtask

  task automatic t_single();
    launch(8'h2B, 0, 1'b0); check_run(8'h2B, 0, 1'b0, 1, "R8 len1");
    launch(8'h77, 0, 1'b1); check_run(8'h77, 0, 1'b0, 1, "R8 len1 ilv");
    launch(8'h3C, 4, 1'b0); check_run(8'h3C, 4, 1'b0, 1, "R10 code4");
    launch(8'h45, 5, 1'b1); check_run(8'h45, 5, 1'b0, 1, "R10 code5");
    launch(8'hE9, 6, 1'b0); check_run(8'hE9, 6, 1'b0, 1, "R10 code6");
  endtask

  task automatic t_restart();
    launch(5, 3, 1'b0); check_run(5, 3, 1'b0, 3, "R9 before");
    launch(8'h43, 2, 1'b1); check_run(8'h43, 2, 1'b1, 4, "R9 after");
    launch(8'h10, 7, 1'b0); check_run(8'h10, 7, 1'b0, 5, "R9 page part");
    launch(8'hA6, 0, 1'b0); check_run(8'hA6, 0, 1'b0, 1, "R9 to len1");
  endtask

  task automatic t_reset_mid();
    launch(1, 3, 1'b0); check_run(1, 3, 1'b0, 2, "R1 mid pre");
    rst = 1'b1;
    @(negedge clk);
    check(col_valid === 1'b0, "R1 mid valid", int'(col_valid), 0);
    check(col_last === 1'b0, "R1 mid last", int'(col_last), 0);
    rst = 1'b0;
    @(negedge clk);
    check(col_valid === 1'b0, "R1 stays idle", int'(col_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sequential();
    t_interleaved();
    t_full_page();
    t_single();
    t_restart();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule